// File: doc/BRIEF.md
# SPI Serial Clock Prescaler Calculator

This block turns a reference clock frequency and a requested SPI bit rate into the two prescaler fields of a serial clock generator. The first field is a 2-bit coarse exponent `div_sel`. The second is a 6-bit fine divider `brg`. The serial clock they produce is `ref / ((2 << div_sel) * 2 * (brg + 1))`. The legal fine values run from 4 to 63 and the legal coarse values from 0 to 3.

A request starts with a one-cycle `start` pulse. The block first finds the truncated integer quotient `q = ref_hz / req_hz` with a restoring divider, one quotient bit per cycle. It then tries the coarse exponents in rising order. For each exponent `d` it forms the candidate `n = q >> (2 + d)`, which is `brg + 1`, and keeps the first exponent whose candidate fits.

A candidate below 5 means the request is too fast: the candidate is raised to 5 at the current exponent. If no exponent fits, the request is too slow: the block returns the slowest setting. Either saturation sets `clamped`. A zero rate request sets `err` and returns no setting. Each result comes with a one-cycle `done` pulse. The result outputs then hold their values until the next `done`.

Top module: `baud_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `err` and `clamped` are 0, and `div_sel` and `brg` are 0.
- R2: For a non-zero request, the quotient is `q = floor(ref_hz / req_hz)`. `div_sel` is the lowest `d` in 0..3 for which `5 <= (q >> (2+d)) <= 64`, `brg` equals `(q >> (2+d)) - 1`, and `clamped` is 0.
- R3: If `(q >> 2) < 5`, the result is `div_sel = 0`, `brg = 4` and `clamped = 1` (too-fast saturation).
- R4: If `(q >> 5) > 64` and no lower exponent fits, the result is `div_sel = 3`, `brg = 63` and `clamped = 1` (too-slow saturation).
- R5: A candidate of exactly 64 is accepted at the current exponent, and a candidate of 65 moves the search to the next exponent.
- R6: A start with `req_hz = 0` gives `done` and `err = 1` on the next cycle, with `div_sel = 0`, `brg = 0`, `clamped = 0`, and without a busy phase.
- R7: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start until `done`, and `done` comes at most 38 cycles after the start.
- R8: A `start` seen while `busy` is high is ignored: the pending result is the one for the first request.
- R9: All divisions truncate toward zero (for example, `ref_hz = 1000` and `req_hz = 3` give `div_sel = 1`, `brg = 40`).
- R10: `div_sel`, `brg`, `clamped` and `err` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| ref_hz | input | 32 | Reference clock frequency in Hz |
| req_hz | input | 32 | Requested serial bit rate in Hz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| err | output | 1 | Last request had a zero rate |
| clamped | output | 1 | Last result was saturated |
| div_sel | output | 2 | Coarse divider exponent |
| brg | output | 6 | Fine divider value (candidate minus one) |

## Verification
A quotient bit that is wrong in the divider shows at the ports as a wrong `brg`, or as an exponent one step off, in the `done` cycle of that request. This happens about 35 cycles after `start`. A search counter that is stuck or skips a value appears as a result at the wrong exponent, or as a missing saturation. If the finishing branch is never reached, `busy` outlasts its bound and the latency check catches it within 38 cycles. A corrupted result register is caught the cycle it changes, because the result fields may only move together with `done`.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_SEARCH = 2'd2
    } sel_state_e;

endpackage

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         done
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W:0]       rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dvs;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = {s_q.rem[W-1:0], s_q.quo[W-1]};
        fits     = (trial >= {1'b0, s_q.dvs});
        if (start && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(W);
            s_d.rem  = '0;
            s_d.quo  = dividend;
            s_d.dvs  = divisor;
        end else if (s_q.busy) begin
            // one restoring step: shift in next dividend bit, try subtract
            s_d.rem = fits ? (trial - {1'b0, s_q.dvs}) : trial;
            s_d.quo = {s_q.quo[W-2:0], fits};
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign quotient = s_q.quo;
    assign done     = s_q.done;

endmodule

// File: rtl/baud_step.sv
module baud_step #(
    parameter int W       = 32,
    parameter int DIV_W   = 2,
    parameter int BRG_W   = 6,
    parameter int BRG_MIN = 4
) (
    input  logic [W-1:0]     quo,
    input  logic [DIV_W-1:0] idx,
    output logic             too_fast,
    output logic             fits,
    output logic [BRG_W-1:0] brg_val
);
    localparam int         N_DIV  = 2 ** DIV_W;
    localparam logic [W-1:0] N_LOW  = W'(BRG_MIN + 1);
    localparam logic [W-1:0] N_HIGH = W'(2 ** BRG_W);

    logic [W-1:0] cand [N_DIV];
    logic [W-1:0] n_sel;

    // candidate for each coarse exponent: q / (4 << d)
    for (genvar d = 0; d < N_DIV; d++) begin : g_cand
        assign cand[d] = quo >> (2 + d);
    end

    assign n_sel    = cand[idx];
    assign too_fast = (n_sel < N_LOW);
    assign fits     = !too_fast && (n_sel <= N_HIGH);

    always_comb begin
        if (too_fast) brg_val = BRG_W'(BRG_MIN);
        else          brg_val = BRG_W'(n_sel - 1'b1);
    end

endmodule

// File: rtl/baud_sel.sv
module baud_sel
    import baud_sel_pkg::*;
#(
    parameter int W       = 32,
    parameter int DIV_W   = 2,
    parameter int BRG_W   = 6,
    parameter int BRG_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     ref_hz,
    input  logic [W-1:0]     req_hz,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             clamped,
    output logic [DIV_W-1:0] div_sel,
    output logic [BRG_W-1:0] brg
);
    localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};
    localparam logic [BRG_W-1:0] BRG_MAX = {BRG_W{1'b1}};

    typedef struct packed {
        sel_state_e       st;
        logic [DIV_W-1:0] idx;
        logic [DIV_W-1:0] div_o;
        logic [BRG_W-1:0] brg_o;
        logic             clamped;
        logic             err;
        logic             done;
    } sel_t;

    sel_t s_d, s_q;

    logic             div_start;
    logic [W-1:0]     quo;
    logic             div_done;
    logic             too_fast;
    logic             fits;
    logic [BRG_W-1:0] brg_val;

    baud_divider #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (ref_hz),
        .divisor  (req_hz),
        .quotient (quo),
        .done     (div_done)
    );

    baud_step #(
        .W(W), .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN)
    ) u_step (
        .quo      (quo),
        .idx      (s_q.idx),
        .too_fast (too_fast),
        .fits     (fits),
        .brg_val  (brg_val)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        div_start = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (req_hz == '0) begin
                        s_d.done    = 1'b1;
                        s_d.err     = 1'b1;
                        s_d.clamped = 1'b0;
                        s_d.div_o   = '0;
                        s_d.brg_o   = '0;
                    end else begin
                        div_start = 1'b1;
                        s_d.st    = ST_DIVIDE;
                    end
                end
            end
            ST_DIVIDE: begin
                if (div_done) begin
                    s_d.st  = ST_SEARCH;
                    s_d.idx = '0;
                end
            end
            ST_SEARCH: begin
                if (too_fast || fits || (s_q.idx == DIV_MAX)) begin
                    s_d.st      = ST_IDLE;
                    s_d.done    = 1'b1;
                    s_d.err     = 1'b0;
                    s_d.div_o   = s_q.idx;
                    s_d.clamped = !fits;
                    s_d.brg_o   = (too_fast || fits) ? brg_val : BRG_MAX;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy    = (s_q.st != ST_IDLE);
    assign done    = s_q.done;
    assign err     = s_q.err;
    assign clamped = s_q.clamped;
    assign div_sel = s_q.div_o;
    assign brg     = s_q.brg_o;

endmodule

// File: rtl/baud_sel_checker.sv
module baud_sel_checker #(
    parameter int W       = 32,
    parameter int DIV_W   = 2,
    parameter int BRG_W   = 6,
    parameter int BRG_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             clamped,
    input logic [DIV_W-1:0] div_sel,
    input logic [BRG_W-1:0] brg
);
    localparam int LIMIT = W + 6;
    localparam int CW    = $clog2(LIMIT + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (!busy)  busy_cnt <= '0;
        else if (busy_cnt != {CW{1'b1}}) busy_cnt <= busy_cnt + 1'b1;
    end

    // R7: done lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the search is over when done shows
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: busy only starts from a start request
    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R7: latency bound through a counter
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CW'(LIMIT));

    // R3, R4: a saturated result is one of the two extreme settings
    a_r3_r4_clamp_values: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clamped) |->
            ((div_sel == '0 && brg == BRG_W'(BRG_MIN)) ||
             (div_sel == {DIV_W{1'b1}} && brg == {BRG_W{1'b1}})));

    // R2: a valid result never falls below the legal fine range
    a_r2_brg_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (brg >= BRG_W'(BRG_MIN)));

    // R6: an error carries no setting
    a_r6_err_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (div_sel == '0 && brg == '0 && !clamped));

    // R10: results move only with done
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(div_sel) && $stable(brg) && $stable(clamped) && $stable(err)));

endmodule

bind baud_sel baud_sel_checker #(
    .W(W), .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .clamped (clamped),
    .div_sel (div_sel),
    .brg     (brg)
);

// File: tb/baud_sel_bench.sv
module baud_sel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0;
    logic [31:0] req_hz = '0;
    logic        busy, done, err, clamped;
    logic [1:0]  div_sel;
    logic [5:0]  brg;

    int n_chk = 0;
    int n_bad = 0;
    int wait_cyc;
    bit finished = 0;

    always #5 clk = ~clk;

    baud_sel u_baud_sel (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .req_hz(req_hz),
        .busy(busy), .done(done), .err(err), .clamped(clamped),
        .div_sel(div_sel), .brg(brg)
    );

    typedef struct packed {
        logic [31:0] r;
        logic [31:0] q;
        logic [1:0]  d;
        logic [5:0]  b;
        logic        c;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{32'd100_000_000, 32'd1_000_000, 2'd0, 6'd24, 1'b0}, // R2
        '{32'd100_000_000, 32'd10_000_000, 2'd0, 6'd4, 1'b1}, // R3
        '{32'd100_000_000, 32'd5_000_000, 2'd0, 6'd4, 1'b0},  // R2 n=5
        '{32'd19, 32'd1, 2'd0, 6'd4, 1'b1},                   // R3 n=4
        '{32'd256, 32'd1, 2'd0, 6'd63, 1'b0},                 // R5 n=64
        '{32'd260, 32'd1, 2'd1, 6'd31, 1'b0},                 // R5 n=65
        '{32'd100_000_000, 32'd100_000, 2'd2, 6'd61, 1'b0},   // R2
        '{32'd100_000_000, 32'd10_000, 2'd3, 6'd63, 1'b1},    // R4
        '{32'd2048, 32'd1, 2'd3, 6'd63, 1'b0},                // R5 top
        '{32'd2080, 32'd1, 2'd3, 6'd63, 1'b1},                // R4 n=65
        '{32'd1000, 32'd3, 2'd1, 6'd40, 1'b0},                // R9
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 6'd4, 1'b1},    // R3 q=1
        '{32'd5, 32'd7, 2'd0, 6'd4, 1'b1},                    // R9 q=0
        '{32'hFFFF_FFFF, 32'd1, 2'd3, 6'd63, 1'b1}            // R4 max
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [31:0] r, input logic [31:0] q);
        @(negedge clk);
        ref_hz = r;
        req_hz = q;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    // after pulse_start returns we sit one cycle past the start edge
    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 fields", {26'd0, div_sel, brg}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {28'd0, busy, done, err, clamped}, 0);

        for (int i = 0; i < NV; i++) begin
            pulse_start(VEC[i].r, VEC[i].q);
            wait_done(wait_cyc);
            check($sformatf("R2/R3/R4/R5/R9 vec%0d result", i),
                  {23'd0, done, err, clamped, div_sel, brg},
                  {23'd0, 1'b1, 1'b0, VEC[i].c, VEC[i].d, VEC[i].b});
            check($sformatf("R7 vec%0d latency", i), 32'(wait_cyc <= 38), 1);
            @(negedge clk);
            check($sformatf("R7 vec%0d done pulse", i), {30'd0, done, busy}, 0);
        end

        // R10: result held while idle
        repeat (15) @(negedge clk);
        check("R10 hold", {24'd0, clamped, div_sel, brg, err}, {24'd0, 1'b1, 2'd3, 6'd63, 1'b0});

        // R6: zero rate request
        pulse_start(32'd100_000_000, 32'd0);
        check("R6 err done", {29'd0, done, err, busy}, 32'b110);
        check("R6 no result", {24'd0, clamped, div_sel, brg}, 0);
        @(negedge clk);
        check("R6 err held", {30'd0, err, done}, 32'b10);

        // R8: second start while busy is ignored
        pulse_start(32'd100_000_000, 32'd1_000_000);
        check("R8 busy", 32'(busy), 1);
        @(negedge clk);
        ref_hz = 32'd19; req_hz = 32'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(wait_cyc);
        check("R8 first request kept", {24'd0, clamped, div_sel, brg}, {24'd0, 1'b0, 2'd0, 6'd24});
        @(negedge clk);
        check("R8 no second result", 32'(busy), 0);
        repeat (45) @(negedge clk);
        check("R8 no late done", {24'd0, clamped, div_sel, brg}, {24'd0, 1'b0, 2'd0, 6'd24});

        // R1: reset mid-calculation clears everything
        pulse_start(32'd100_000_000, 32'd100_000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", {22'd0, busy, done, err, clamped, div_sel, brg}, 0);
        rst_n = 1'b1;
        finished = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(negedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule